// File: doc/BRIEF.md
# Translation cache with hardware table walker

This block translates virtual addresses from a CPU load/store port into physical addresses. Pages are 4 KiB: the low 12 bits of an address pass through unchanged and the upper bits form the virtual page number. A small, fully associative store of recent translations answers a hit in the same cycle. On a miss, the block stalls the CPU and reads one entry from a single-level page table in memory. The table is an array indexed by virtual page number, and its start address comes from a base input. The block then installs the entry, or reports a page fault if the table marks the page absent.

Each cached translation tracks a reference bit and a dirty bit. A hit sets the reference bit, and a write hit also sets the dirty bit. A clear input drops every cached reference bit at once. Whenever a cached status bit changes, the block writes the entry back to its slot in the table, so memory always holds the current status and nothing is lost when an entry is evicted. Victims are chosen by least-recently-used order, which is kept as a per-entry age.

The memory side uses a valid/ready request channel, shared by table reads and write-backs, and a valid/ready response channel for read data. The request valid and all request fields stay stable until ready is seen high on a clock edge; memory may hold ready low for any number of cycles. A response is taken only in a cycle where the block drives response-ready high. The memory must answer read requests in order, and write requests produce no response. On the CPU side, the request is held with a stable address until the hit is seen or a fault is reported. After a fault the CPU must drop the request; if it keeps the request high, the walk repeats.

Top module: `pgx_xlat`

## Requirements
- R1: After reset no translation is cached, no memory request is pending, the stall output is low with no CPU request, and the first access to any page walks the table.
- R2: A CPU request whose page is cached returns `{ppn, va[11:0]}` on `cpu_pa` with `cpu_hit` high and `cpu_stall` low in the same cycle.
- R3: A request that misses keeps `cpu_stall` high until the refill completes. The walk issues exactly one read at `pt_base + 4*vpn`, and the held request then hits with the fetched physical page.
- R4: A table entry is `PA_W` bits: bit 0 present, bit 1 reference, bit 2 dirty, bits `[PA_W-1:12]` physical page number, and bits 11:3 written as zero.
- R5: When the fetched entry has present = 0, `fault_valid` is high for exactly one cycle with `fault_va` equal to the full faulting address. Nothing is installed, so a repeat of the same access walks again.
- R6: A hit on a page whose reference bit is clear sets the bit and writes the entry back to its table slot with reference = 1.
- R7: A write hit on a clean page sets the dirty bit and writes the entry back. A hit that changes no status bit causes no write.
- R8: A one-cycle pulse on `clr_ref` clears the reference bits of all cached entries, and each entry whose bit was set is written back with reference = 0 and its dirty bit unchanged.
- R9: A fill goes into the lowest-numbered empty slot. When all slots are full, it replaces the least recently used entry, where both hits and fills count as uses.
- R10: A memory request keeps valid, address, write flag and write data stable until accepted, and each request is issued exactly once.
- R11: An entry's changed status reaches the table before the entry can be replaced, so an evicted page's slot holds its latest reference and dirty bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pt_base | input | PA_W | Physical start address of the page table |
| clr_ref | input | 1 | Pulse: clear all cached reference bits |
| cpu_req | input | 1 | CPU access request, held until hit or fault |
| cpu_we | input | 1 | Access is a write |
| cpu_va | input | VA_W | Virtual address of the access |
| cpu_hit | output | 1 | Translation available this cycle |
| cpu_pa | output | PA_W | Physical address, valid when cpu_hit |
| cpu_stall | output | 1 | Request pending without translation |
| fault_valid | output | 1 | One-cycle page-fault report |
| fault_va | output | VA_W | Faulting virtual address |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 = entry write-back, 0 = entry read |
| mem_req_addr | output | PA_W | Byte address of the table slot |
| mem_req_wdata | output | PA_W | Entry written back |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_ready | output | 1 | Block takes read data |
| mem_rsp_data | input | PA_W | Table entry read from memory |

## Verification
The translation path is tried with cold misses, repeated hits on a filled page, reads against writes, and absent pages. Together these separate the same-cycle hit path from the stalled walk and from the fault path. Status tracking is exercised with a first hit, a first write, a repeated unchanged access and a bulk reference clear. Each pattern shows in the table image whether a write-back happened and with which bits. Filling every slot, touching the oldest entry, clearing references and then forcing one more fill distinguishes correct LRU choice and empty-slot-first placement from other orders. It also shows that the evicted page's status was flushed first. The walk is finally repeated under memory back-pressure to show that each request is issued once and kept intact.

// File: rtl/pgx_pkg.sv
package pgx_pkg;
  // Page offset width (4 KiB pages)
  localparam int PG_OFF_W = 12;
  // Table entry status bit positions
  localparam int PTE_PRES  = 0;
  localparam int PTE_REF   = 1;
  localparam int PTE_DIRTY = 2;

  typedef enum logic [2:0] {
    W_IDLE,
    W_FLUSH,
    W_RD,
    W_WAIT,
    W_FAULT
  } walk_st_t;
endpackage

// File: rtl/pgx_lru.sv
module pgx_lru #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          touch_en,
  input  logic [IW-1:0] touch_idx,
  input  logic [N-1:0]  valid,
  output logic [IW-1:0] victim_idx
);
  // age 0 = most recent, N-1 = oldest; always a permutation of 0..N-1
  logic [IW-1:0] age [N];
  logic          have_free;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) age[i] <= IW'(i);
    end else if (touch_en) begin
      for (int i = 0; i < N; i++) begin
        if (IW'(i) == touch_idx)        age[i] <= '0;
        else if (age[i] < age[touch_idx]) age[i] <= age[i] + 1'b1;
      end
    end
  end

  always_comb begin
    victim_idx = '0;
    have_free  = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid[i]) begin
        victim_idx = IW'(i);
        have_free  = 1'b1;
      end
    end
    if (!have_free) begin
      for (int i = 0; i < N; i++)
        if (age[i] == IW'(N - 1)) victim_idx = IW'(i);
    end
  end
endmodule

// File: rtl/pgx_cam.sv
module pgx_cam #(
  parameter int N     = 8,
  parameter int IW    = $clog2(N),
  parameter int VPN_W = 20,
  parameter int PPN_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic             acc_en,
  input  logic             acc_we,
  input  logic             clr_ref,
  input  logic             fill_en,
  input  logic [IW-1:0]    fill_idx,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             fill_ref,
  input  logic             fill_dirty,
  input  logic             take_en,
  input  logic [IW-1:0]    take_idx,
  input  logic [IW-1:0]    peek_idx,
  output logic             hit,
  output logic [IW-1:0]    hit_idx,
  output logic [PPN_W-1:0] hit_ppn,
  output logic [N-1:0]     match_vec,
  output logic [N-1:0]     valid_vec,
  output logic             any_stale,
  output logic [IW-1:0]    stale_idx,
  output logic [VPN_W-1:0] peek_vpn,
  output logic [PPN_W-1:0] peek_ppn,
  output logic             peek_ref,
  output logic             peek_dirty,
  output logic             peek_stale
);
  logic [N-1:0]     vld, rf, dt, stl, acc;
  logic [VPN_W-1:0] e_vpn [N];
  logic [PPN_W-1:0] e_ppn [N];

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match_vec[g] = vld[g] && (e_vpn[g] == lk_vpn);
    assign acc[g]       = acc_en && match_vec[g];
  end

  assign valid_vec = vld;
  assign hit       = |match_vec;

  always_comb begin
    hit_idx = '0;
    hit_ppn = '0;
    for (int i = 0; i < N; i++) begin
      if (match_vec[i]) begin
        hit_idx = hit_idx | IW'(i);
        hit_ppn = hit_ppn | e_ppn[i];
      end
    end
  end

  always_comb begin
    any_stale = |stl;
    stale_idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (stl[i]) stale_idx = IW'(i);
  end

  assign peek_vpn   = e_vpn[peek_idx];
  assign peek_ppn   = e_ppn[peek_idx];
  assign peek_ref   = rf[peek_idx];
  assign peek_dirty = dt[peek_idx];
  assign peek_stale = stl[peek_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
      rf  <= '0;
      dt  <= '0;
      stl <= '0;
      for (int i = 0; i < N; i++) begin
        e_vpn[i] <= '0;
        e_ppn[i] <= '0;
      end
    end else begin
      for (int i = 0; i < N; i++) begin
        if (fill_en && fill_idx == IW'(i)) begin
          vld[i]   <= 1'b1;
          e_vpn[i] <= fill_vpn;
          e_ppn[i] <= fill_ppn;
          rf[i]    <= fill_ref;
          dt[i]    <= fill_dirty;
          stl[i]   <= 1'b0;
        end else begin
          rf[i] <= acc[i] ? 1'b1 : (clr_ref ? 1'b0 : rf[i]);
          dt[i] <= dt[i] | (acc[i] & acc_we);
          // a new status change wins over the flush taking the old one
          if (vld[i] && ((acc[i] && (!rf[i] || (acc_we && !dt[i])))
                         || (clr_ref && rf[i] && !acc[i])))
            stl[i] <= 1'b1;
          else if (take_en && take_idx == IW'(i))
            stl[i] <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/pgx_walk.sv
module pgx_walk #(
  parameter int VA_W = 32,
  parameter int PA_W = 32
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [PA_W-1:0]                    pt_base,
  input  logic                               miss,
  input  logic [VA_W-1:0]                    miss_va,
  input  logic                               any_stale,
  input  logic [VA_W-pgx_pkg::PG_OFF_W-1:0]  peek_vpn,
  input  logic [PA_W-pgx_pkg::PG_OFF_W-1:0]  peek_ppn,
  input  logic                               peek_ref,
  input  logic                               peek_dirty,
  input  logic                               peek_stale,
  output logic                               mem_req_valid,
  input  logic                               mem_req_ready,
  output logic                               mem_req_we,
  output logic [PA_W-1:0]                    mem_req_addr,
  output logic [PA_W-1:0]                    mem_req_wdata,
  input  logic                               mem_rsp_valid,
  output logic                               mem_rsp_ready,
  input  logic [PA_W-1:0]                    mem_rsp_data,
  output logic                               hits_ok,
  output logic                               take_en,
  output logic                               peek_victim,
  output logic                               fill_en,
  output logic [VA_W-pgx_pkg::PG_OFF_W-1:0]  fill_vpn,
  output logic [PA_W-pgx_pkg::PG_OFF_W-1:0]  fill_ppn,
  output logic                               fill_ref,
  output logic                               fill_dirty,
  output logic                               fault_valid,
  output logic [VA_W-1:0]                    fault_va
);
  import pgx_pkg::*;
  localparam int VPN_W = VA_W - PG_OFF_W;
  localparam int PPN_W = PA_W - PG_OFF_W;

  walk_st_t        st;
  logic [PA_W-1:0] rq_addr, rq_wdata;
  logic            rq_we;
  logic [VA_W-1:0] wk_va;
  logic            rsp_present;
  logic            unused_rsv;

  function automatic logic [PA_W-1:0] slot_of(input logic [PA_W-1:0] base,
                                              input logic [VPN_W-1:0] v);
    return base + (PA_W'(v) << 2);
  endfunction

  function automatic logic [PA_W-1:0] pack(input logic [PPN_W-1:0] p,
                                           input logic r, input logic d);
    return {p, {(PG_OFF_W-3){1'b0}}, d, r, 1'b1};
  endfunction

  assign rsp_present = mem_rsp_data[PTE_PRES];
  assign unused_rsv  = ^mem_rsp_data[PG_OFF_W-1:3];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= W_IDLE;
      rq_addr  <= '0;
      rq_wdata <= '0;
      rq_we    <= 1'b0;
      wk_va    <= '0;
    end else begin
      case (st)
        W_IDLE: begin
          if (any_stale) begin
            rq_addr  <= slot_of(pt_base, peek_vpn);
            rq_wdata <= pack(peek_ppn, peek_ref, peek_dirty);
            rq_we    <= 1'b1;
            st       <= W_FLUSH;
          end else if (miss) begin
            wk_va   <= miss_va;
            rq_addr <= slot_of(pt_base, miss_va[VA_W-1:PG_OFF_W]);
            rq_we   <= 1'b0;
            st      <= W_RD;
          end
        end
        W_FLUSH: if (mem_req_ready) st <= W_IDLE;
        W_RD:    if (mem_req_ready) st <= W_WAIT;
        W_WAIT: begin
          if (mem_rsp_valid) begin
            if (!rsp_present) begin
              st <= W_FAULT;
            end else if (peek_stale) begin
              // victim carries unsaved status: save it before it is lost
              rq_addr  <= slot_of(pt_base, peek_vpn);
              rq_wdata <= pack(peek_ppn, peek_ref, peek_dirty);
              rq_we    <= 1'b1;
              st       <= W_FLUSH;
            end else begin
              st <= W_IDLE;
            end
          end
        end
        W_FAULT: st <= W_IDLE;
        default: st <= W_IDLE;
      endcase
    end
  end

  assign mem_req_valid = (st == W_FLUSH) || (st == W_RD);
  assign mem_req_we    = rq_we;
  assign mem_req_addr  = rq_addr;
  assign mem_req_wdata = rq_wdata;
  assign mem_rsp_ready = (st == W_WAIT);
  assign hits_ok       = (st == W_IDLE) || (st == W_FLUSH);
  assign take_en       = (st == W_IDLE) && any_stale;
  assign peek_victim   = (st == W_WAIT);
  assign fill_en       = (st == W_WAIT) && mem_rsp_valid && rsp_present;
  assign fill_vpn      = wk_va[VA_W-1:PG_OFF_W];
  assign fill_ppn      = mem_rsp_data[PA_W-1:PG_OFF_W];
  assign fill_ref      = mem_rsp_data[PTE_REF];
  assign fill_dirty    = mem_rsp_data[PTE_DIRTY];
  assign fault_valid   = (st == W_FAULT);
  assign fault_va      = wk_va;
endmodule

// File: rtl/pgx_xlat.sv
module pgx_xlat #(
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int ENTRIES = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PA_W-1:0] pt_base,
  input  logic            clr_ref,
  input  logic            cpu_req,
  input  logic            cpu_we,
  input  logic [VA_W-1:0] cpu_va,
  output logic            cpu_hit,
  output logic [PA_W-1:0] cpu_pa,
  output logic            cpu_stall,
  output logic            fault_valid,
  output logic [VA_W-1:0] fault_va,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic            mem_req_we,
  output logic [PA_W-1:0] mem_req_addr,
  output logic [PA_W-1:0] mem_req_wdata,
  input  logic            mem_rsp_valid,
  output logic            mem_rsp_ready,
  input  logic [PA_W-1:0] mem_rsp_data
);
  import pgx_pkg::*;
  localparam int VPN_W = VA_W - PG_OFF_W;
  localparam int PPN_W = PA_W - PG_OFF_W;
  localparam int IW    = $clog2(ENTRIES);

  logic             hit, hits_ok, any_stale, take_en, peek_victim, fill_en;
  logic             peek_ref, peek_dirty, peek_stale, fill_ref, fill_dirty;
  logic [IW-1:0]    hit_idx, stale_idx, victim_idx, peek_idx, touch_idx;
  logic [PPN_W-1:0] hit_ppn, peek_ppn, fill_ppn;
  logic [VPN_W-1:0] peek_vpn, fill_vpn;
  logic [ENTRIES-1:0] hit_vec, valid_vec;
  logic             miss, touch_en;

  assign cpu_hit   = cpu_req && hit && hits_ok;
  assign cpu_pa    = {hit_ppn, cpu_va[PG_OFF_W-1:0]};
  assign cpu_stall = cpu_req && !cpu_hit;
  assign miss      = cpu_req && !hit;
  assign touch_en  = cpu_hit || fill_en;
  assign touch_idx = fill_en ? victim_idx : hit_idx;
  assign peek_idx  = peek_victim ? victim_idx : stale_idx;

  pgx_cam #(.N(ENTRIES), .IW(IW), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_cam (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_vpn     (cpu_va[VA_W-1:PG_OFF_W]),
    .acc_en     (cpu_hit),
    .acc_we     (cpu_we),
    .clr_ref    (clr_ref),
    .fill_en    (fill_en),
    .fill_idx   (victim_idx),
    .fill_vpn   (fill_vpn),
    .fill_ppn   (fill_ppn),
    .fill_ref   (fill_ref),
    .fill_dirty (fill_dirty),
    .take_en    (take_en),
    .take_idx   (stale_idx),
    .peek_idx   (peek_idx),
    .hit        (hit),
    .hit_idx    (hit_idx),
    .hit_ppn    (hit_ppn),
    .match_vec  (hit_vec),
    .valid_vec  (valid_vec),
    .any_stale  (any_stale),
    .stale_idx  (stale_idx),
    .peek_vpn   (peek_vpn),
    .peek_ppn   (peek_ppn),
    .peek_ref   (peek_ref),
    .peek_dirty (peek_dirty),
    .peek_stale (peek_stale)
  );

  pgx_lru #(.N(ENTRIES), .IW(IW)) u_lru (
    .clk        (clk),
    .rst_n      (rst_n),
    .touch_en   (touch_en),
    .touch_idx  (touch_idx),
    .valid      (valid_vec),
    .victim_idx (victim_idx)
  );

  pgx_walk #(.VA_W(VA_W), .PA_W(PA_W)) u_walk (
    .clk           (clk),
    .rst_n         (rst_n),
    .pt_base       (pt_base),
    .miss          (miss),
    .miss_va       (cpu_va),
    .any_stale     (any_stale),
    .peek_vpn      (peek_vpn),
    .peek_ppn      (peek_ppn),
    .peek_ref      (peek_ref),
    .peek_dirty    (peek_dirty),
    .peek_stale    (peek_stale),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_we    (mem_req_we),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_ready (mem_rsp_ready),
    .mem_rsp_data  (mem_rsp_data),
    .hits_ok       (hits_ok),
    .take_en       (take_en),
    .peek_victim   (peek_victim),
    .fill_en       (fill_en),
    .fill_vpn      (fill_vpn),
    .fill_ppn      (fill_ppn),
    .fill_ref      (fill_ref),
    .fill_dirty    (fill_dirty),
    .fault_valid   (fault_valid),
    .fault_va      (fault_va)
  );
endmodule

// File: rtl/pgx_chk.sv
module pgx_chk #(
  parameter int N    = 8,
  parameter int PA_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic            mem_req_we,
  input logic [PA_W-1:0] mem_req_addr,
  input logic [PA_W-1:0] mem_req_wdata,
  input logic            mem_rsp_ready,
  input logic            cpu_hit,
  input logic            fault_valid,
  input logic [N-1:0]    match_vec
);
  // R10: request held intact while memory back-pressures
  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_we) && $stable(mem_req_wdata));

  // R9: a page never sits in two slots
  a_r9_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));

  // R3: no translation is served while a walk waits for data
  a_r3_walk_nohit: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_ready |-> !cpu_hit);

  // R5: fault report lasts one cycle
  a_r5_fault_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |=> !fault_valid);

  // R5: a fault cycle never also reports a hit
  a_r5_fault_nohit: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |-> !cpu_hit);
endmodule

bind pgx_xlat pgx_chk #(.N(ENTRIES), .PA_W(PA_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_we    (mem_req_we),
  .mem_req_addr  (mem_req_addr),
  .mem_req_wdata (mem_req_wdata),
  .mem_rsp_ready (mem_rsp_ready),
  .cpu_hit       (cpu_hit),
  .fault_valid   (fault_valid),
  .match_vec     (hit_vec)
);

// File: tb/tb_pgx_xlat.sv
module tb_pgx_xlat;
  localparam logic [31:0] BASE = 32'h0004_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pt_base = BASE;
  logic        clr_ref = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [31:0] cpu_va = '0;
  logic        cpu_hit, cpu_stall, fault_valid;
  logic [31:0] cpu_pa, fault_va;
  logic        mem_req_valid, mem_req_ready, mem_req_we;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic        mem_rsp_valid, mem_rsp_ready;
  logic [31:0] mem_rsp_data;

  int total = 0, bad = 0;
  int rd_cnt = 0, wr_cnt = 0, bad_addr = 0;
  logic [31:0] last_rd_addr = '0;
  logic [31:0] pt [64];
  bit bp_mode = 1'b0;

  always #10 clk = ~clk;

  pgx_xlat dut (
    .clk(clk), .rst_n(rst_n), .pt_base(pt_base), .clr_ref(clr_ref),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_va(cpu_va),
    .cpu_hit(cpu_hit), .cpu_pa(cpu_pa), .cpu_stall(cpu_stall),
    .fault_valid(fault_valid), .fault_va(fault_va),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data)
  );

  // memory model: samples transfers at the edge, drives at the falling edge
  initial begin : mem_model
    bit pend;
    int lat, cyc, idx;
    logic [31:0] pdata;
    pend = 0; lat = 0; cyc = 0; pdata = '0;
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    forever begin
      @(posedge clk);
      if (!rst_n) begin
        pend = 0;
      end else begin
        if (mem_rsp_valid && mem_rsp_ready) pend = 0;
        if (mem_req_valid && mem_req_ready) begin
          idx = int'((mem_req_addr - BASE) >> 2);
          if (mem_req_addr < BASE || idx > 63 || mem_req_addr[1:0] != 2'b00) begin
            bad_addr++;
          end else if (mem_req_we) begin
            pt[idx] = mem_req_wdata;
            wr_cnt++;
          end else begin
            rd_cnt++;
            last_rd_addr = mem_req_addr;
            pend = 1; lat = 2; pdata = pt[idx];
          end
        end else if (pend && lat > 0) begin
          lat--;
        end
      end
      cyc++;
      @(negedge clk);
      mem_req_ready = bp_mode ? (cyc % 3 == 2) : 1'b1;
      mem_rsp_valid = pend && (lat == 0);
      mem_rsp_data  = pend ? pdata : 32'hdead_beef;
    end
  end

  task automatic finish_up();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run hung, actual=expired expected=done");
    finish_up();
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pte(input logic [19:0] ppn, input bit p,
                                      input bit r, input bit d);
    return {ppn, 9'b0, d, r, p};
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cpu_req = 1'b0; clr_ref = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic drain();
    repeat (30) @(negedge clk);
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr_ref = 1'b1;
    @(negedge clk); clr_ref = 1'b0;
  endtask

  // hold a request until hit or fault; cycles = samples spent stalled
  task automatic access(input logic [31:0] va, input bit we,
                        output logic [31:0] pa, output bit flt,
                        output logic [31:0] fva, output int cycles,
                        output bit gap);
    bit done;
    @(negedge clk);
    cpu_va = va; cpu_we = we; cpu_req = 1'b1;
    pa = '0; flt = 0; fva = '0; cycles = 0; gap = 0; done = 0;
    while (!done) begin
      #5;
      if (cpu_hit) begin
        pa = cpu_pa; done = 1;
      end else if (fault_valid) begin
        flt = 1; fva = fault_va; done = 1;
      end else begin
        if (!cpu_stall) gap = 1;
        cycles++;
        if (cycles > 500) done = 1;
      end
      @(negedge clk);
    end
    cpu_req = 1'b0;
  endtask

  task automatic t_reset();
    #5;
    check(cpu_stall == 1'b0, "R1 stall low after reset", 32'(cpu_stall), 0);
    check(mem_req_valid == 1'b0, "R1 no request after reset", 32'(mem_req_valid), 0);
    check(fault_valid == 1'b0, "R1 no fault after reset", 32'(fault_valid), 0);
  endtask

  task automatic t_miss_hit();
    logic [31:0] pa, fva; bit f, gap; int cyc, rd0;
    rd0 = rd_cnt;
    access(32'h0000_3abc, 0, pa, f, fva, cyc, gap);
    check(pa == 32'h0005_5abc, "R3 refill translation", pa, 32'h0005_5abc);
    check(cyc > 0 && !gap, "R3 stall held through walk", 32'(cyc), 1);
    check(rd_cnt == rd0 + 1, "R3 one table read", 32'(rd_cnt - rd0), 1);
    check(last_rd_addr == BASE + 12, "R4 slot address", last_rd_addr, BASE + 12);
    access(32'h0000_3123, 0, pa, f, fva, cyc, gap);
    check(cyc == 0, "R2 same-cycle hit", 32'(cyc), 0);
    check(pa == 32'h0005_5123, "R2 hit address", pa, 32'h0005_5123);
  endtask

  task automatic t_ref_dirty();
    logic [31:0] pa, fva; bit f, gap; int cyc, wr0;
    drain();
    check(pt[3] == pte(20'h00055, 1, 1, 0), "R6 reference written back", pt[3],
          pte(20'h00055, 1, 1, 0));
    wr0 = wr_cnt;
    access(32'h0000_3004, 1, pa, f, fva, cyc, gap);
    drain();
    check(pt[3] == pte(20'h00055, 1, 1, 1), "R7 dirty written back", pt[3],
          pte(20'h00055, 1, 1, 1));
    check(wr_cnt == wr0 + 1, "R7 one write for dirty", 32'(wr_cnt - wr0), 1);
    wr0 = wr_cnt;
    access(32'h0000_3008, 1, pa, f, fva, cyc, gap);
    drain();
    check(wr_cnt == wr0, "R7 unchanged status no write", 32'(wr_cnt - wr0), 0);
  endtask

  task automatic t_clear();
    logic [31:0] pa, fva; bit f, gap; int cyc;
    pulse_clr();
    drain();
    check(pt[3] == pte(20'h00055, 1, 0, 1), "R8 reference cleared, dirty kept",
          pt[3], pte(20'h00055, 1, 0, 1));
    access(32'h0000_3000, 0, pa, f, fva, cyc, gap);
    drain();
    check(pt[3][1] == 1'b1, "R6 reference set again after clear", 32'(pt[3][1]), 1);
  endtask

  task automatic t_fault();
    logic [31:0] pa, fva; bit f, gap; int cyc, rd0, wr0;
    rd0 = rd_cnt; wr0 = wr_cnt;
    access(32'h0000_9f04, 0, pa, f, fva, cyc, gap);
    check(f == 1'b1, "R5 fault raised", 32'(f), 1);
    check(fva == 32'h0000_9f04, "R5 fault address", fva, 32'h0000_9f04);
    #5;
    check(fault_valid == 1'b0, "R5 fault one cycle", 32'(fault_valid), 0);
    access(32'h0000_9f04, 0, pa, f, fva, cyc, gap);
    check(f == 1'b1 && rd_cnt == rd0 + 2, "R5 nothing installed", 32'(rd_cnt - rd0), 2);
    check(wr_cnt == wr0, "R5 no table write on fault", 32'(wr_cnt - wr0), 0);
  endtask

  task automatic t_lru();
    logic [31:0] pa, fva; bit f, gap; int cyc, rd0; bit all_hit;
    do_reset();
    access(32'h0000_3000, 0, pa, f, fva, cyc, gap);
    check(cyc > 0, "R1 cache empty after reset", 32'(cyc), 1);
    do_reset();
    for (int v = 16; v <= 24; v++) pt[v] = pte(20'(32'h100 + v), 1, 0, 0);
    rd0 = rd_cnt;
    for (int v = 16; v <= 23; v++) access(32'(v) << 12, 0, pa, f, fva, cyc, gap);
    check(rd_cnt == rd0 + 8, "R9 eight fills", 32'(rd_cnt - rd0), 8);
    all_hit = 1;
    for (int v = 16; v <= 23; v++) begin
      access((32'(v) << 12) | 32'h10, 0, pa, f, fva, cyc, gap);
      if (cyc != 0) all_hit = 0;
    end
    check(all_hit, "R9 empty slots used first", 32'(all_hit), 1);
    access(32'h0001_0020, 0, pa, f, fva, cyc, gap);
    drain();
    pulse_clr();
    rd0 = rd_cnt;
    access(32'h0001_8000, 0, pa, f, fva, cyc, gap);
    check(pa == 32'h0011_8000, "R3 ninth page translation", pa, 32'h0011_8000);
    drain();
    check(pt[17] == pte(20'h111, 1, 0, 0), "R11 evicted status in table", pt[17],
          pte(20'h111, 1, 0, 0));
    access(32'h0001_0000, 0, pa, f, fva, cyc, gap);
    check(cyc == 0, "R9 recently used page kept", 32'(cyc), 0);
    access(32'h0001_1000, 0, pa, f, fva, cyc, gap);
    check(cyc > 0 && rd_cnt == rd0 + 2, "R9 oldest page evicted", 32'(rd_cnt - rd0), 2);
  endtask

  task automatic t_backpressure();
    logic [31:0] pa, fva; bit f, gap; int cyc, rd0;
    bp_mode = 1;
    do_reset();
    pt[5] = pte(20'h0abcd, 1, 0, 0);
    rd0 = rd_cnt;
    access(32'h0000_5678, 1, pa, f, fva, cyc, gap);
    check(pa == 32'h0abc_d678, "R10 translation under back-pressure", pa, 32'h0abc_d678);
    check(rd_cnt == rd0 + 1, "R10 read issued once", 32'(rd_cnt - rd0), 1);
    check(last_rd_addr == BASE + 20, "R10 read address intact", last_rd_addr, BASE + 20);
    drain();
    check(pt[5] == pte(20'h0abcd, 1, 1, 1), "R10 write-back intact", pt[5],
          pte(20'h0abcd, 1, 1, 1));
    bp_mode = 0;
  endtask

  initial begin : main
    for (int i = 0; i < 64; i++) pt[i] = '0;
    pt[3] = pte(20'h00055, 1, 0, 0);
    pt[9] = pte(20'h00077, 0, 0, 0);
    do_reset();
    t_reset();
    t_miss_hit();
    t_ref_dirty();
    t_clear();
    t_fault();
    t_lru();
    t_backpressure();
    check(bad_addr == 0, "R4 all requests inside table", 32'(bad_addr), 0);
    finish_up();
  end
endmodule